// File: doc/BRIEF.md
# DDS Serial Register Loader

This block programs an external direct-digital-synthesis device over a three-wire serial link made of an active-low frame strobe, a serial clock and a data line. The controlling logic supplies a precomputed 28-bit tuning word, a 12-bit phase word, a choice between the two frequency registers and the two phase registers of the target, and a flag that selects a full or a partial frequency update. A one-cycle start pulse then launches a fixed transaction. The first 16-bit word is a mode word. One or two frequency words follow, and a phase word comes last.

The inputs are captured when the start pulse is accepted. The controller may change them while the transfer runs. A busy flag covers the whole transaction, and a one-cycle done pulse marks its end. Converting a requested frequency into a tuning word is left to the controller: the word is round(f_out * 2^28 / f_ref), rounded and not truncated. The synthesis core is outside this block.

Top module: `dds_word_loader`

## Requirements
- R1: The first word of each transaction is the mode word {2'b00, full, 1'b0, fsel, psel, 10'b0}.
- R2: With full=1, two frequency words follow the mode word, low half first. Each word is {tag, 14 tuning bits}, with tag 2'b01 for register 0 and 2'b10 for register 1. The first word carries tune[13:0] and the second carries tune[27:14].
- R3: With full=0, exactly one frequency word follows the mode word. It carries the register tag and tune[13:0].
- R4: The last word is the phase word {3'b110, psel, phase[11:0]}. The transaction holds 4 words when full=1 and 3 when full=0.
- R5: Frame strobe is low for exactly 16 falling serial-clock edges per word, and bits are sent MSB first.
- R6: Data changes only while the serial clock is high, so it is stable at each falling edge.
- R7: Frame strobe stays high for at least CLK_DIV system cycles between words.
- R8: Busy rises the cycle after an accepted start and stays high while any frame is active.
- R9: Done is a single-cycle pulse in the first cycle with busy low after a transaction.
- R10: A start pulse while busy is ignored: neither the words being sent nor the word count change.
- R11: After reset the frame strobe and the serial clock are high, and busy and done are low.
- R12: The serial clock period is CLK_DIV system cycles, with the clock idling high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Single-cycle request to begin a transaction |
| tune | input | 28 | Frequency tuning word |
| phase | input | 12 | Phase offset word |
| fsel | input | 1 | Frequency register to write and activate |
| psel | input | 1 | Phase register to write and activate |
| full | input | 1 | 1 sends both tuning halves, 0 sends only the low half |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| sync_n | output | 1 | Active-low frame strobe |
| sclk | output | 1 | Serial clock, idle high |
| sdata | output | 1 | Serial data, MSB first |

## Verification
On every cycle the assertions watch the link timing: the 16 falls per frame, data moving only while the serial clock is high, the minimum strobe-high gap, and the busy and done handshake, including frames that occur only under busy. Whether each word carries the right tags, the right selects and the right tuning half, in the right order, can only be shown by the bench. The bench decodes the serial stream and compares it with words built from the inputs. It also covers the ignored mid-transfer start and the serial clock period.

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [27:0] tune,
  input  logic [11:0] phase,
  input  logic        fsel,
  input  logic        psel,
  input  logic        full,
  output logic        busy,
  output logic        done,
  output logic        sync_n,
  output logic        sclk,
  output logic        sdata
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DW   = $clog2(CLK_DIV + 1);
  localparam logic [DW-1:0] HALF_M1 = DW'(HALF - 1);
  localparam logic [DW-1:0] PER_M1  = DW'(CLK_DIV - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP} st_t;

  st_t         st;
  logic [DW-1:0] div_cnt;
  logic [3:0]  bit_cnt;
  logic [1:0]  widx;
  logic [15:0] sh;
  logic [27:0] l_tune;
  logic [11:0] l_phase;
  logic        l_fsel, l_psel, l_full;
  logic        sclk_r, sync_r, busy_r, done_r;
  logic [1:0]  nxt_idx;

  function automatic logic [15:0] word_of(input logic [1:0] idx, input logic [27:0] tw,
                                          input logic [11:0] ph, input logic fs,
                                          input logic ps, input logic fl);
    logic [1:0] tag;
    tag = fs ? 2'b10 : 2'b01;
    case (idx)
      2'd0:    word_of = {2'b00, fl, 1'b0, fs, ps, 10'b0};
      2'd1:    word_of = {tag, tw[13:0]};
      2'd2:    word_of = {tag, tw[27:14]};
      default: word_of = {3'b110, ps, ph};
    endcase
  endfunction

  assign nxt_idx = (widx == 2'd1 && !l_full) ? 2'd3 : widx + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      bit_cnt <= '0;
      widx    <= '0;
      sh      <= '0;
      l_tune  <= '0;
      l_phase <= '0;
      l_fsel  <= 1'b0;
      l_psel  <= 1'b0;
      l_full  <= 1'b0;
      sclk_r  <= 1'b1;
      sync_r  <= 1'b1;
      busy_r  <= 1'b0;
      done_r  <= 1'b0;
    end else begin
      done_r <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          l_tune  <= tune;
          l_phase <= phase;
          l_fsel  <= fsel;
          l_psel  <= psel;
          l_full  <= full;
          sh      <= word_of(2'd0, tune, phase, fsel, psel, full);
          widx    <= 2'd0;
          bit_cnt <= '0;
          div_cnt <= '0;
          sclk_r  <= 1'b1;
          sync_r  <= 1'b0;
          busy_r  <= 1'b1;
          st      <= S_SHIFT;
        end
        S_SHIFT: begin
          if (div_cnt == HALF_M1) begin
            div_cnt <= '0;
            if (sclk_r) begin
              sclk_r <= 1'b0;
            end else begin
              sclk_r <= 1'b1;
              if (bit_cnt == 4'd15) begin
                sync_r <= 1'b1;
                st     <= S_GAP;
              end else begin
                bit_cnt <= bit_cnt + 4'd1;
                sh      <= {sh[14:0], 1'b0};
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        S_GAP: begin
          if (div_cnt == PER_M1) begin
            div_cnt <= '0;
            if (widx == 2'd3) begin
              busy_r <= 1'b0;
              done_r <= 1'b1;
              st     <= S_IDLE;
            end else begin
              widx    <= nxt_idx;
              sh      <= word_of(nxt_idx, l_tune, l_phase, l_fsel, l_psel, l_full);
              bit_cnt <= '0;
              sync_r  <= 1'b0;
              st      <= S_SHIFT;
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy   = busy_r;
  assign done   = done_r;
  assign sync_n = sync_r;
  assign sclk   = sclk_r;
  assign sdata  = sh[15];
endmodule

// File: rtl/dds_loader_chk.sv
module dds_loader_chk #(
  parameter int CLK_DIV = 4
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sync_n,
  input logic sclk,
  input logic sdata
);
  logic [4:0]  fall_cnt;
  logic [15:0] hi_cnt;
  logic        sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= '0;
      hi_cnt   <= 16'hFFFF;
      sclk_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      if (sync_n) fall_cnt <= '0;
      else if (sclk_q && !sclk) fall_cnt <= fall_cnt + 5'd1;
      if (!sync_n) hi_cnt <= '0;
      else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
    end
  end

  AST_SIXTEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_n) |-> fall_cnt == 5'd16); // R5
  AST_DATA_CHANGES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata) |-> sclk); // R6
  AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> hi_cnt >= 16'(CLK_DIV)); // R7
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_FRAME_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> busy); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk); // R12
endmodule

bind dds_word_loader dds_loader_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sync_n(sync_n), .sclk(sclk), .sdata(sdata)
);

// File: tb/sim_dds_word_loader.sv
module sim_dds_word_loader;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [27:0] tune = '0;
  logic [11:0] phase = '0;
  logic fsel = 1'b0, psel = 1'b0, full = 1'b0;
  logic busy, done, sync_n, sclk, sdata;

  int checks = 0, fails = 0;
  int cyc = 0;

  logic [15:0] frames [0:7];
  int          fbits  [0:7];
  int          nfr = 0, nbits = 0;
  logic [15:0] shreg = '0;
  logic        p_sclk = 1'b1, p_sync = 1'b1, p_sdata = 1'b0;
  int          last_fall = 0, hi_run = 100;
  bit          per_bad = 0, stab_bad = 0, gap_bad = 0, clr = 0;

  always #5 clk = ~clk;

  dds_word_loader #(.CLK_DIV(CLK_DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tune(tune), .phase(phase),
    .fsel(fsel), .psel(psel), .full(full), .busy(busy), .done(done),
    .sync_n(sync_n), .sclk(sclk), .sdata(sdata)
  );

  always @(negedge clk) begin
    cyc++;
    if (clr) begin
      nfr = 0; nbits = 0; per_bad = 0; stab_bad = 0; gap_bad = 0; clr = 0;
    end
    if (!sync_n && p_sync && hi_run < CLK_DIV) gap_bad = 1;
    if (sync_n) hi_run++; else hi_run = 0;
    if (!sync_n && p_sclk && !sclk) begin
      if (sdata != p_sdata) stab_bad = 1;
      if (nbits > 0 && cyc - last_fall != CLK_DIV) per_bad = 1;
      last_fall = cyc;
      shreg = {shreg[14:0], sdata};
      nbits++;
    end
    if (sync_n && !p_sync) begin
      if (nfr < 8) begin frames[nfr] = shreg; fbits[nfr] = nbits; end
      nfr++;
      nbits = 0;
    end
    p_sclk = sclk; p_sync = sync_n; p_sdata = sdata;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] e_ctl(input logic fl, input logic fs, input logic ps);
    return {2'b00, fl, 1'b0, fs, ps, 10'b0};
  endfunction
  function automatic logic [15:0] e_frq(input logic fs, input logic [13:0] v);
    return {(fs ? 2'b10 : 2'b01), v};
  endfunction
  function automatic logic [15:0] e_ph(input logic ps, input logic [11:0] p);
    return {3'b110, ps, p};
  endfunction

  task automatic run(input logic [27:0] tw, input logic [11:0] ph, input logic fs,
                     input logic ps, input logic fl, input bit intrude);
    int n;
    int w;
    @(negedge clk);
    clr = 1;
    tune = tw; phase = ph; fsel = fs; psel = ps; full = fl; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    tune = ~tw; phase = ~ph; fsel = ~fs; psel = ~ps; full = ~fl;
    if (intrude) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done && !busy, "R9 done with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R9 done single cycle", done, 0);
    n = fl ? 4 : 3;
    chk(nfr == n, intrude ? "R10 word count with start while busy" : "R4 word count", nfr, n);
    if (nfr == n) begin
      chk(frames[0] == e_ctl(fl, fs, ps), "R1 mode word", frames[0], e_ctl(fl, fs, ps));
      chk(frames[1] == e_frq(fs, tw[13:0]), fl ? "R2 low tuning word" : "R3 single tuning word",
          frames[1], e_frq(fs, tw[13:0]));
      if (fl) chk(frames[2] == e_frq(fs, tw[27:14]), "R2 high tuning word",
                  frames[2], e_frq(fs, tw[27:14]));
      chk(frames[n-1] == e_ph(ps, ph), intrude ? "R10 phase word unchanged" : "R4 phase word",
          frames[n-1], e_ph(ps, ph));
      w = 0;
      for (int i = 0; i < n; i++) if (fbits[i] != 16) w++;
      chk(w == 0, "R5 sixteen bits per word", w, 0);
    end
    chk(!stab_bad, "R6 data stable at fall", stab_bad, 0);
    chk(!gap_bad, "R7 frame gap", gap_bad, 0);
    chk(!per_bad, "R12 serial clock period", per_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(sync_n && sclk && !busy && !done, "R11 reset state",
        {sync_n, sclk, busy, done}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sync_n && sclk && !busy && !done, "R11 idle after reset",
        {sync_n, sclk, busy, done}, 4'b1100);
    run(28'h0000000, 12'h000, 1'b0, 1'b0, 1'b1, 0);
    run(28'hFFFFFFF, 12'hFFF, 1'b1, 1'b1, 1'b1, 0);
    run(28'hAAAA555, 12'h5A5, 1'b0, 1'b1, 1'b0, 0);
    run(28'h0003FFF, 12'h800, 1'b1, 1'b0, 1'b0, 0);
    run(28'h1234567, 12'h321, 1'b1, 1'b0, 1'b1, 1);
    for (int k = 0; k < 30; k++)
      run(28'($urandom), 12'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          ($urandom % 4) == 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule